// File: doc/BRIEF.md
# Queue Level Interrupt and DMA Request Unit

This unit sits beside the transmit command queue and the receive data queue of a serial bus master. It tracks how full each queue is from push and pop strobes, and compares those fill levels against thresholds that software programs. From the comparisons it produces raw interrupt status, a masked interrupt line, the receive fill count, a receive-not-empty flag, and one DMA request line per direction. Each request line has an acknowledge handshake.

Thresholds and watermarks are separate for each direction. The transmit side asks for service when its level falls to or below a value. The receive side asks for service when its level climbs to or above a value. A push to a full queue or a pop from an empty queue is refused, and leaves a sticky error bit that software clears by writing ones. After each DMA acknowledge the matching request is withheld for one cycle, so every single transfer is followed by a fresh level comparison.

Top module: `qlvl_dma_unit`

## Requirements
- R1: After reset both levels are 0, all four sticky bits are 0, both DMA requests are low, and the interrupt output is low.
- R2: Each level holds a count from 0 to DEPTH (default 16). An accepted push adds one and an accepted pop subtracts one, and a push and pop that are both accepted in the same cycle leave the level unchanged. Push and pop are each judged against the level before the clock edge.
- R3: A push at level DEPTH is refused and sets the overflow bit. A pop at level 0 is refused and sets the underflow bit. In both cases the level does not change. In the status word, bit 2 is receive overflow, bit 3 is receive underflow, bit 4 is transmit overflow and bit 5 is transmit underflow.
- R4: A sticky bit stays set until a clear strobe bit is 1 in a cycle. Clear bits 0..3 map to status bits 2..5. A new error in the same cycle as its clear leaves the bit set.
- R5: Status bit 0 (receive full) is 1 exactly while the receive level is greater than the receive threshold.
- R6: Status bit 1 (transmit low) is 1 exactly while the transmit level is less than or equal to the transmit threshold.
- R7: The interrupt output is the OR of status bits ANDed with the mask (1 = pass). The mask does not change the status word.
- R8: The receive level output equals the receive queue count, and the not-empty flag is 1 exactly when that count is nonzero.
- R9: The transmit request is high when DMA enable bit 1 is set and the transmit level is at or below the transmit watermark. A watermark above DEPTH counts as DEPTH.
- R10: The receive request is high when DMA enable bit 0 is set and the receive level is at or above the receive watermark. A watermark above DEPTH counts as DEPTH.
- R11: In the cycle that follows an acknowledge on a direction, that direction's request is low, whatever the level comparison gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Transmit queue write strobe |
| tx_pop | input | 1 | Transmit queue read strobe |
| rx_push | input | 1 | Receive queue write strobe |
| rx_pop | input | 1 | Receive queue read strobe |
| tx_thresh | input | 5 | Transmit-low interrupt threshold |
| rx_thresh | input | 5 | Receive-full interrupt threshold |
| tx_wmark | input | 5 | Transmit DMA watermark |
| rx_wmark | input | 5 | Receive DMA watermark |
| dma_en | input | 2 | Bit 1 transmit request enable, bit 0 receive request enable |
| irq_mask | input | 6 | Per-status interrupt pass mask |
| sticky_clr | input | 4 | Write-one-to-clear strobes for status bits 5..2 |
| tx_dma_ack | input | 1 | Transmit DMA acknowledge |
| rx_dma_ack | input | 1 | Receive DMA acknowledge |
| status | output | 6 | Raw interrupt status word |
| irq | output | 1 | Masked interrupt |
| rx_level | output | 5 | Receive queue count |
| rx_not_empty | output | 1 | Receive queue holds data |
| tx_level | output | 5 | Transmit queue count |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest state to reach from the ports is a queue sitting at a full or empty edge while simultaneous push and pop strobes, a clear strobe and an acknowledge all arrive at once. Plain random strobes hover near half full, so the stimulus runs in phases that weight pushes over pops and then the reverse, driving each queue against both ends repeatedly. Each phase reprograms thresholds and watermarks, including values above the depth. Clear strobes and acknowledges are sprinkled at random, so they coincide with fresh errors and with live requests.

// File: rtl/qlvl_pkg.sv
package qlvl_pkg;
  localparam int ST_RX_FULL = 0;
  localparam int ST_TX_LOW  = 1;
  localparam int ST_RX_OVF  = 2;
  localparam int ST_RX_UDF  = 3;
  localparam int ST_TX_OVF  = 4;
  localparam int ST_TX_UDF  = 5;
  localparam int ST_W       = 6;
  localparam int STICKY_W   = 4;
  localparam int STICKY_LSB = 2;
endpackage

// File: rtl/qlvl_counter.sv
module qlvl_counter #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] level,
  output logic          ovf,
  output logic          udf
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] level_q, level_d;
  logic          push_ok, pop_ok;

  always_comb begin
    push_ok = push && (level_q != FULL);
    pop_ok  = pop  && (level_q != '0);
    ovf     = push && !push_ok;
    udf     = pop  && !pop_ok;
    level_d = level_q;
    if (push_ok && !pop_ok) level_d = level_q + 1'b1;
    if (pop_ok && !push_ok) level_d = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 level_q <= '0;
    else if (push_ok || pop_ok) level_q <= level_d;
  end

  assign level = level_q;
endmodule

// File: rtl/qlvl_dma_req.sv
module qlvl_dma_req #(
  parameter int DEPTH    = 16,
  parameter int LW       = $clog2(DEPTH + 1),
  parameter bit LOW_SIDE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] wmark,
  input  logic          ack,
  output logic          req
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] wm_sat;
  logic          hit;
  logic          gap_q, gap_d;

  assign wm_sat = (wmark > FULL) ? FULL : wmark;

  generate
    if (LOW_SIDE) begin : g_low
      assign hit = (level <= wm_sat);
    end else begin : g_high
      assign hit = (level >= wm_sat);
    end
  endgenerate

  always_comb begin
    gap_d = ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= 1'b1;
    else if (gap_q != gap_d)     gap_q <= gap_d;
  end

  assign req = en && hit && !gap_q;
endmodule

// File: rtl/qlvl_dma_unit.sv
module qlvl_dma_unit
  import qlvl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_push,
  input  logic                tx_pop,
  input  logic                rx_push,
  input  logic                rx_pop,
  input  logic [LW-1:0]       tx_thresh,
  input  logic [LW-1:0]       rx_thresh,
  input  logic [LW-1:0]       tx_wmark,
  input  logic [LW-1:0]       rx_wmark,
  input  logic [1:0]          dma_en,
  input  logic [ST_W-1:0]     irq_mask,
  input  logic [STICKY_W-1:0] sticky_clr,
  input  logic                tx_dma_ack,
  input  logic                rx_dma_ack,
  output logic [ST_W-1:0]     status,
  output logic                irq,
  output logic [LW-1:0]       rx_level,
  output logic                rx_not_empty,
  output logic [LW-1:0]       tx_level,
  output logic                tx_dma_req,
  output logic                rx_dma_req
);
  logic rx_ovf, rx_udf, tx_ovf, tx_udf;
  logic [STICKY_W-1:0] err_set, sticky_q, sticky_d;

  qlvl_counter #(.DEPTH(DEPTH), .LW(LW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .level(rx_level), .ovf(rx_ovf), .udf(rx_udf));

  qlvl_counter #(.DEPTH(DEPTH), .LW(LW)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
    .level(tx_level), .ovf(tx_ovf), .udf(tx_udf));

  qlvl_dma_req #(.DEPTH(DEPTH), .LW(LW), .LOW_SIDE(1'b1)) u_txreq (
    .clk(clk), .rst_n(rst_n), .en(dma_en[1]), .level(tx_level),
    .wmark(tx_wmark), .ack(tx_dma_ack), .req(tx_dma_req));

  qlvl_dma_req #(.DEPTH(DEPTH), .LW(LW), .LOW_SIDE(1'b0)) u_rxreq (
    .clk(clk), .rst_n(rst_n), .en(dma_en[0]), .level(rx_level),
    .wmark(rx_wmark), .ack(rx_dma_ack), .req(rx_dma_req));

  // Order matches status bits 5..2
  assign err_set = {tx_udf, tx_ovf, rx_udf, rx_ovf};

  always_comb begin
    sticky_d = (sticky_q & ~sticky_clr) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sticky_q <= '0;
    else if (sticky_d != sticky_q) sticky_q <= sticky_d;
  end

  always_comb begin
    status                       = '0;
    status[ST_RX_FULL]           = (rx_level > rx_thresh);
    status[ST_TX_LOW]            = (tx_level <= tx_thresh);
    status[ST_W-1:STICKY_LSB]    = sticky_q;
  end

  assign irq          = |(status & irq_mask);
  assign rx_not_empty = (rx_level != '0);
endmodule

// File: rtl/qlvl_dma_unit_chk.sv
module qlvl_dma_unit_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          tx_dma_ack,
  input logic          rx_dma_ack,
  input logic [5:0]    status,
  input logic [5:0]    irq_mask,
  input logic          irq,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          tx_dma_req,
  input logic          rx_dma_req
);
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH)));

  a_r2_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_level < LW'(DEPTH)) |=> rx_level == $past(rx_level) + 1'b1);

  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_level == LW'(DEPTH)) |=> status[2] && rx_level == LW'(DEPTH));

  a_r3_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push && rx_level == '0) |=> status[3] && rx_level == '0);

  a_r7_irq_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & irq_mask)) |-> irq);

  a_r11_tx_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dma_ack |=> !tx_dma_req);

  a_r11_rx_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_ack |=> !rx_dma_req);
endmodule

bind qlvl_dma_unit qlvl_dma_unit_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop),
  .tx_dma_ack(tx_dma_ack), .rx_dma_ack(rx_dma_ack), .status(status),
  .irq_mask(irq_mask), .irq(irq), .rx_level(rx_level), .tx_level(tx_level),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

// File: tb/test_qlvl_dma_unit.sv
module test_qlvl_dma_unit;
  localparam int DEPTH = 16;
  localparam int LW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [LW-1:0] tx_thresh = 0, rx_thresh = 0, tx_wmark = 0, rx_wmark = 0;
  logic [1:0] dma_en = 0;
  logic [5:0] irq_mask = 0;
  logic [3:0] sticky_clr = 0;
  logic tx_dma_ack = 0, rx_dma_ack = 0;
  logic [5:0] status;
  logic irq, rx_not_empty, tx_dma_req, rx_dma_req;
  logic [LW-1:0] rx_level, tx_level;

  int checks = 0;
  int fails  = 0;

  // model state
  int m_tx = 0, m_rx = 0;
  logic [3:0] m_sticky = 0;
  logic m_txgap = 1, m_rxgap = 1;

  always #4 clk = ~clk;

  qlvl_dma_unit #(.DEPTH(DEPTH)) i_qlvl_dma_unit (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_thresh(tx_thresh),
    .rx_thresh(rx_thresh), .tx_wmark(tx_wmark), .rx_wmark(rx_wmark),
    .dma_en(dma_en), .irq_mask(irq_mask), .sticky_clr(sticky_clr),
    .tx_dma_ack(tx_dma_ack), .rx_dma_ack(rx_dma_ack), .status(status),
    .irq(irq), .rx_level(rx_level), .rx_not_empty(rx_not_empty),
    .tx_level(tx_level), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  function automatic int sat(input int wm);
    return (wm > DEPTH) ? DEPTH : wm;
  endfunction

  function automatic logic [5:0] exp_status();
    logic [5:0] s;
    s[0] = (m_rx > int'(rx_thresh));
    s[1] = (m_tx <= int'(tx_thresh));
    s[5:2] = m_sticky;
    return s;
  endfunction

  function automatic logic exp_txreq();
    return dma_en[1] && (m_tx <= sat(int'(tx_wmark))) && !m_txgap;
  endfunction

  function automatic logic exp_rxreq();
    return dma_en[0] && (m_rx >= sat(int'(rx_wmark))) && !m_rxgap;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [5:0] es;
    es = exp_status();
    check("R2 tx_level", int'(tx_level), m_tx);
    check("R8 rx_level", int'(rx_level), m_rx);
    check("R8 rx_not_empty", int'(rx_not_empty), int'(m_rx != 0));
    check("R5 rx_full", int'(status[0]), int'(es[0]));
    check("R6 tx_low", int'(status[1]), int'(es[1]));
    check("R3 R4 sticky", int'(status[5:2]), int'(es[5:2]));
    check("R7 irq", int'(irq), int'(|(es & irq_mask)));
    check("R9 R11 tx_dma_req", int'(tx_dma_req), int'(exp_txreq()));
    check("R10 R11 rx_dma_req", int'(rx_dma_req), int'(exp_rxreq()));
  endtask

  task automatic model_step();
    logic [3:0] e;
    logic tpu, tpo, rpu, rpo;
    tpu = tx_push && m_tx != DEPTH; tpo = tx_pop && m_tx != 0;
    rpu = rx_push && m_rx != DEPTH; rpo = rx_pop && m_rx != 0;
    e = {tx_pop && !tpo, tx_push && !tpu, rx_pop && !rpo, rx_push && !rpu};
    m_tx = m_tx + int'(tpu) - int'(tpo);
    m_rx = m_rx + int'(rpu) - int'(rpo);
    m_sticky = (m_sticky & ~sticky_clr) | e;
    m_txgap = tx_dma_ack;
    m_rxgap = rx_dma_ack;
  endtask

  // one cycle: inputs already driven after a negedge; check, then clock
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pbias;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rx_level", int'(rx_level), 0);
    check("R1 tx_level", int'(tx_level), 0);
    check("R1 sticky", int'(status[5:2]), 0);
    check("R1 reqs", int'({tx_dma_req, rx_dma_req}), 0);
    check("R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed R3: pop empty, then R4 clear with coincident new error
    rx_pop = 1; tx_pop = 1; cycle();
    rx_pop = 0; tx_pop = 0; cycle();
    sticky_clr = 4'b1111; rx_pop = 1; cycle();
    sticky_clr = 0; rx_pop = 0; cycle();
    sticky_clr = 4'b0100; cycle();
    sticky_clr = 0;

    // directed R10 saturation: fill rx to full with watermark 31
    dma_en = 2'b11; rx_wmark = 5'd31; tx_wmark = 5'd31;
    for (int i = 0; i < DEPTH + 2; i++) begin rx_push = 1; cycle(); end
    rx_push = 0; rx_dma_ack = 1; cycle();
    rx_dma_ack = 0; cycle();

    // random phases
    for (int ph = 0; ph < 48; ph++) begin
      pbias = (ph % 2 == 0) ? 85 : 15;
      tx_thresh = 5'($urandom_range(0, 20));
      rx_thresh = 5'($urandom_range(0, 20));
      tx_wmark  = 5'($urandom_range(0, 31));
      rx_wmark  = 5'($urandom_range(0, 31));
      dma_en    = 2'($urandom);
      irq_mask  = 6'($urandom);
      for (int c = 0; c < 60; c++) begin
        tx_push    = ($urandom_range(0, 99) < pbias);
        tx_pop     = ($urandom_range(0, 99) < 100 - pbias);
        rx_push    = ($urandom_range(0, 99) < pbias);
        rx_pop     = ($urandom_range(0, 99) < 100 - pbias);
        sticky_clr = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
        tx_dma_ack = tx_dma_req && ($urandom_range(0, 2) == 0);
        rx_dma_ack = ($urandom_range(0, 3) == 0);
        cycle();
      end
    end
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    sticky_clr = 0; tx_dma_ack = 0; rx_dma_ack = 0;
    cycle();

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule